// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers a vector of level-sensitive interrupt sources into a single masked request for a primary interrupt controller. Each source is captured into a level register every clock. Software can also raise any line through a software-interrupt register, and those bits are ORed into the effective level before masking. The OR of all masked effective levels is registered and driven on one output line, chosen by a parameter.

A window of source lines, 21 to 30 by default, can also be routed straight to the primary controller. Each of these lines has its own passthrough-enable bit. An enabled line follows its captured input level on the output line with the same index. A disabled line is held low.

Software reaches the block through a word-indexed bus with separate read and write strobes. The register index is the byte offset divided by four. The enable registers use separate set and clear indices, so no read-modify-write is needed.

Top module: `sec_irq_ctrl`

## Requirements
- R1: `irq_i` is captured into a level register on every clock edge. A read of index 1 returns that level register, which does not include software-interrupt bits.
- R2: Output `irq_o[COMB_IDX]` (default 31) is a register. It is loaded with the OR over all bits of ((level | soft) & mask), so it reflects a level, mask or software change one clock after that change.
- R3: A read of index 0 returns (level | soft) & mask.
- R4: A write to index 2 ORs `wdata_i` into the mask. A write to index 3 clears the mask bits that are set in `wdata_i`. A read of index 2 returns the mask.
- R5: A write to index 4 sets software-interrupt bits and a write to index 5 clears them. A read of index 4 returns the software-interrupt register.
- R6: A write to index 8 ORs `wdata_i & 0x7FE00000` (bits 21..30) into the passthrough-enable register. A read of index 8 returns that register.
- R7: A write to index 9 clears the passthrough-enable bits that are set in `wdata_i`.
- R8: For each line i in 21..30, `irq_o[i]` equals level[i] AND passthrough-enable[i]. It changes on the same edge that captures the level, so a disabled line is low.
- R9: Output lines outside 21..30, other than `COMB_IDX`, stay low.
- R10: Reads of indices other than 0, 1, 2, 4 and 8 return zero. Writes to indices other than 2, 3, 4, 5, 8 and 9 change no state.
- R11: Reset (`rst_ni` low, asynchronous) clears the mask, software-interrupt, passthrough-enable and level registers, `rdata_o`, and all outputs.
- R12: `rdata_o` is loaded on the clock edge at which `rd_i` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Level-sensitive interrupt sources |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 32 | Passthrough lines plus combined request at COMB_IDX |

## Verification
The combined request is driven in three ways. A source is raised with its mask clear and then set, which separates masking from level capture and pins the one-cycle latency. A software bit is raised with all inputs low, which shows that soft bits reach the request but not the raw level read. The passthrough window is driven with all-ones inputs and an all-ones enable write. This separates the in-range lines from the out-of-range bits, which must remain low, and a partial clear shows that only the named lines drop.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int IDX_STATUS   = 0;
  localparam int IDX_RAW      = 1;
  localparam int IDX_MASK_SET = 2;
  localparam int IDX_MASK_CLR = 3;
  localparam int IDX_SOFT_SET = 4;
  localparam int IDX_SOFT_CLR = 5;
  localparam int IDX_PT_SET   = 8;
  localparam int IDX_PT_CLR   = 9;

  // contiguous bit span lo..hi, up to 64 lines
  function automatic logic [63:0] span_mask(int lo, int hi);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/sic_regs.sv
module sic_regs #(
  parameter int N_IRQ  = 32,
  parameter int ADDR_W = 4,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_IRQ-1:0]  wdata_i,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [N_IRQ-1:0]  soft_o,
  output logic [N_IRQ-1:0]  pten_o
);
  localparam logic [N_IRQ-1:0] PT_MASK = N_IRQ'(sic_pkg::span_mask(PT_LO, PT_HI));

  logic [N_IRQ-1:0] mask_q, soft_q, pten_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      soft_q <= '0;
      pten_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_W'(sic_pkg::IDX_MASK_SET): mask_q <= mask_q | wdata_i;
        ADDR_W'(sic_pkg::IDX_MASK_CLR): mask_q <= mask_q & ~wdata_i;
        ADDR_W'(sic_pkg::IDX_SOFT_SET): soft_q <= soft_q | wdata_i;
        ADDR_W'(sic_pkg::IDX_SOFT_CLR): soft_q <= soft_q & ~wdata_i;
        ADDR_W'(sic_pkg::IDX_PT_SET):   pten_q <= pten_q | (wdata_i & PT_MASK);
        ADDR_W'(sic_pkg::IDX_PT_CLR):   pten_q <= pten_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign soft_o = soft_q;
  assign pten_o = pten_q;
endmodule

// File: rtl/sic_core.sv
module sic_core #(
  parameter int N_IRQ    = 32,
  parameter int PT_LO    = 21,
  parameter int PT_HI    = 30,
  parameter int COMB_IDX = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic [N_IRQ-1:0] soft_i,
  input  logic [N_IRQ-1:0] pten_i,
  output logic [N_IRQ-1:0] level_o,
  output logic [N_IRQ-1:0] status_o,
  output logic [N_IRQ-1:0] irq_o
);
  localparam logic [N_IRQ-1:0] PT_MASK  = N_IRQ'(sic_pkg::span_mask(PT_LO, PT_HI));
  localparam logic [N_IRQ-1:0] CMB_BIT  = N_IRQ'(sic_pkg::span_mask(COMB_IDX, COMB_IDX));

  logic [N_IRQ-1:0] level_q;
  logic             req_q;

  assign status_o = (level_q | soft_i) & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      req_q   <= 1'b0;
    end else begin
      level_q <= irq_i;
      req_q   <= |status_o;
    end
  end

  // combined line wins if it overlaps the passthrough window
  assign irq_o = (level_q & pten_i & PT_MASK & ~CMB_BIT) | (req_q ? CMB_BIT : '0);
  assign level_o = level_q;
endmodule

// File: rtl/sic_rdata.sv
module sic_rdata #(
  parameter int N_IRQ  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_IRQ-1:0]  status_i,
  input  logic [N_IRQ-1:0]  level_i,
  input  logic [N_IRQ-1:0]  mask_i,
  input  logic [N_IRQ-1:0]  soft_i,
  input  logic [N_IRQ-1:0]  pten_i,
  output logic [N_IRQ-1:0]  rdata_o
);
  logic [N_IRQ-1:0] sel_d, rdata_q;

  always_comb begin
    case (addr_i)
      ADDR_W'(sic_pkg::IDX_STATUS):   sel_d = status_i;
      ADDR_W'(sic_pkg::IDX_RAW):      sel_d = level_i;
      ADDR_W'(sic_pkg::IDX_MASK_SET): sel_d = mask_i;
      ADDR_W'(sic_pkg::IDX_SOFT_SET): sel_d = soft_i;
      ADDR_W'(sic_pkg::IDX_PT_SET):   sel_d = pten_i;
      default:                        sel_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int N_IRQ    = 32,
  parameter int ADDR_W   = 4,
  parameter int PT_LO    = 21,
  parameter int PT_HI    = 30,
  parameter int COMB_IDX = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_IRQ-1:0]  wdata_i,
  output logic [N_IRQ-1:0]  rdata_o,
  output logic [N_IRQ-1:0]  irq_o
);
  logic [N_IRQ-1:0] mask_q, soft_q, pten_q, level_q, status_w;

  sic_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .mask_o(mask_q), .soft_o(soft_q), .pten_o(pten_q)
  );

  sic_core #(.N_IRQ(N_IRQ), .PT_LO(PT_LO), .PT_HI(PT_HI), .COMB_IDX(COMB_IDX)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .mask_i(mask_q), .soft_i(soft_q),
    .pten_i(pten_q), .level_o(level_q), .status_o(status_w), .irq_o(irq_o)
  );

  sic_rdata #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_rdata (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i), .status_i(status_w),
    .level_i(level_q), .mask_i(mask_q), .soft_i(soft_q), .pten_i(pten_q), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/sec_irq_ctrl_chk.sv
module sec_irq_ctrl_chk #(
  parameter int N_IRQ    = 32,
  parameter int ADDR_W   = 4,
  parameter int PT_LO    = 21,
  parameter int PT_HI    = 30,
  parameter int COMB_IDX = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_IRQ-1:0]  wdata_i,
  input logic [N_IRQ-1:0]  irq_o,
  input logic [N_IRQ-1:0]  mask_q,
  input logic [N_IRQ-1:0]  soft_q,
  input logic [N_IRQ-1:0]  pten_q,
  input logic [N_IRQ-1:0]  level_q
);
  localparam logic [N_IRQ-1:0] PT_MASK = N_IRQ'(sic_pkg::span_mask(PT_LO, PT_HI));
  localparam logic [N_IRQ-1:0] CMB_BIT = N_IRQ'(sic_pkg::span_mask(COMB_IDX, COMB_IDX));

  logic wr_known;
  assign wr_known = (addr_i == ADDR_W'(sic_pkg::IDX_MASK_SET)) || (addr_i == ADDR_W'(sic_pkg::IDX_MASK_CLR)) ||
                    (addr_i == ADDR_W'(sic_pkg::IDX_SOFT_SET)) || (addr_i == ADDR_W'(sic_pkg::IDX_SOFT_CLR)) ||
                    (addr_i == ADDR_W'(sic_pkg::IDX_PT_SET))   || (addr_i == ADDR_W'(sic_pkg::IDX_PT_CLR));

  // R2
  comb_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[COMB_IDX] == $past(|((level_q | soft_q) & mask_q)));
  // R4
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(sic_pkg::IDX_MASK_SET)) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R4
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(sic_pkg::IDX_MASK_CLR)) |=> ((mask_q & $past(wdata_i)) == '0));
  // R5
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(sic_pkg::IDX_SOFT_CLR)) |=> ((soft_q & $past(wdata_i)) == '0));
  // R6
  pt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(sic_pkg::IDX_PT_SET)) |=> (pten_q == ($past(pten_q) | ($past(wdata_i) & PT_MASK))));
  // R7
  pt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(sic_pkg::IDX_PT_CLR)) |=> ((pten_q & $past(wdata_i)) == '0));
  // R8
  pt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & PT_MASK & ~CMB_BIT & ~pten_q) == '0);
  // R9
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~PT_MASK & ~CMB_BIT) == '0);
  // R10
  bad_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_known) |=> ($stable(mask_q) && $stable(soft_q) && $stable(pten_q)));
endmodule

bind sec_irq_ctrl sec_irq_ctrl_chk #(
  .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI), .COMB_IDX(COMB_IDX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .irq_o(irq_o), .mask_q(mask_q), .soft_q(soft_q), .pten_q(pten_q), .level_q(level_q)
);

// File: tb/sec_irq_ctrl_test.sv
module sec_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sec_irq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int idx, logic [31:0] val);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 4'(idx); wdata_i = val;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(int idx, output logic [31:0] val);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = 4'(idx);
    @(negedge clk_i);
    rd_i = 1'b0;
    val = rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R11 irq_o after reset", irq_o, 32'h0);
    check("R11 rdata after reset", rdata_o, 32'h0);
    reg_rd(2, v); check("R11 mask", v, 32'h0);
    reg_rd(4, v); check("R11 soft", v, 32'h0);
    reg_rd(8, v); check("R11 pten", v, 32'h0);
  endtask

  task automatic t_level_mask();
    logic [31:0] v;
    @(negedge clk_i); irq_i = 32'h0000_0010;
    @(negedge clk_i);
    reg_rd(1, v); check("R1 raw level", v, 32'h0000_0010);
    reg_rd(0, v); check("R3 status unmasked", v, 32'h0);
    check("R2 no req while masked", {31'h0, irq_o[31]}, 32'h0);
    reg_wr(2, 32'h0000_0110);
    check("R2 req one cycle late", {31'h0, irq_o[31]}, 32'h0);
    @(negedge clk_i);
    check("R2 req asserted", {31'h0, irq_o[31]}, 32'h1);
    reg_rd(2, v); check("R4 mask readback", v, 32'h0000_0110);
    reg_rd(0, v); check("R3 status masked", v, 32'h0000_0010);
    reg_wr(3, 32'h0000_0010);
    @(negedge clk_i);
    check("R2 req drops after mask clear", {31'h0, irq_o[31]}, 32'h0);
    reg_rd(2, v); check("R4 mask after clear", v, 32'h0000_0100);
    // level drop alone clears the request
    reg_wr(2, 32'h0000_0010);
    @(negedge clk_i); irq_i = 32'h0;
    @(negedge clk_i);
    check("R2 req holds one cycle after level drop", {31'h0, irq_o[31]}, 32'h1);
    @(negedge clk_i);
    check("R2 req after level drop", {31'h0, irq_o[31]}, 32'h0);
    reg_wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    reg_wr(2, 32'h0000_0100);
    reg_wr(4, 32'h0000_0300);
    @(negedge clk_i);
    check("R5 soft raises req", {31'h0, irq_o[31]}, 32'h1);
    reg_rd(4, v); check("R5 soft readback", v, 32'h0000_0300);
    reg_rd(1, v); check("R1 raw excludes soft", v, 32'h0);
    reg_rd(0, v); check("R3 status with soft", v, 32'h0000_0100);
    reg_wr(5, 32'h0000_0100);
    @(negedge clk_i);
    check("R5 soft clear drops req", {31'h0, irq_o[31]}, 32'h0);
    reg_rd(4, v); check("R5 soft after clear", v, 32'h0000_0200);
    reg_wr(5, 32'hFFFF_FFFF);
    reg_wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_passthrough();
    logic [31:0] v;
    reg_wr(8, 32'hFFFF_FFFF);
    reg_rd(8, v); check("R6 pten window only", v, 32'h7FE0_0000);
    @(negedge clk_i); irq_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    check("R8 R9 lines follow level", irq_o, 32'h7FE0_0000);
    irq_i = 32'hFDFF_FFFF; // drop line 25
    @(negedge clk_i);
    check("R8 line 25 follows drop", irq_o, 32'h7DE0_0000);
    reg_wr(9, 32'h00C0_0000);
    check("R7 cleared lines go low", irq_o, 32'h7D20_0000);
    reg_rd(8, v); check("R7 pten after clear", v, 32'h7F20_0000);
    reg_wr(9, 32'hFFFF_FFFF);
    check("R8 all disabled", irq_o, 32'h0);
    @(negedge clk_i); irq_i = 32'h0;
  endtask

  task automatic t_undefined();
    logic [31:0] v;
    reg_wr(2, 32'h0000_00F0);
    reg_wr(4, 32'h0000_0F00);
    reg_wr(8, 32'h0060_0000);
    reg_wr(6, 32'hFFFF_FFFF);
    reg_wr(7, 32'hFFFF_FFFF);
    reg_wr(10, 32'hFFFF_FFFF);
    reg_wr(15, 32'hFFFF_FFFF);
    reg_rd(2, v); check("R10 mask untouched", v, 32'h0000_00F0);
    reg_rd(4, v); check("R10 soft untouched", v, 32'h0000_0F00);
    reg_rd(8, v); check("R10 pten untouched", v, 32'h0060_0000);
    reg_rd(3, v); check("R10 read idx3", v, 32'h0);
    reg_rd(5, v); check("R10 read idx5", v, 32'h0);
    reg_rd(9, v); check("R10 read idx9", v, 32'h0);
    reg_rd(15, v); check("R10 read idx15", v, 32'h0);
  endtask

  task automatic t_hold_and_reset();
    logic [31:0] v;
    reg_rd(2, v);
    reg_wr(2, 32'h0000_000F);
    @(negedge clk_i);
    check("R12 rdata holds without rd", rdata_o, 32'h0000_00F0);
    do_reset();
    check("R11 irq_o cleared", irq_o, 32'h0);
    check("R11 rdata cleared", rdata_o, 32'h0);
    reg_rd(2, v); check("R11 mask cleared", v, 32'h0);
    reg_rd(4, v); check("R11 soft cleared", v, 32'h0);
    reg_rd(8, v); check("R11 pten cleared", v, 32'h0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_level_mask();
    t_soft();
    t_passthrough();
    t_undefined();
    t_hold_and_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule